// File: doc/BRIEF.md
# USB Serial Receive Front End

This block sits between a differential line receiver and the packet layer of a USB device. Its inputs are line samples that are already synchronised to the system clock, together with a one-cycle strobe from the clock-recovery logic that marks the centre of each bit. On every strobe the block classifies the line as J, K, single-ended zero (SE0) or the illegal SE1 state. A mode input selects whether J means D+ high (full speed, 12 Mbit/s) or D- high (low speed, 1.5 Mbit/s).

A bit decoder turns the J/K stream into NRZI-decoded bits and hunts for the SYNC field. When SYNC is found, a byte enable opens. Stuffed bits are then dropped, and the remaining bits are packed least significant bit first into bytes. Each byte is written into a 32-entry receive FIFO. The FIFO's full flag serves as the interrupt. The end-of-packet condition closes the byte enable. A line monitor beside the decoder reports end of packet, idle, bus reset and resume on their own outputs. The packet layer drains the FIFO through a show-ahead read port.

Top module: `usb_rx_front`

## Requirements
- R1: Each strobed sample is classified from {line_dp,line_dm}: 00 is SE0, 11 is SE1, and 10 is J when low_speed=0 and K when low_speed=1. The pair 01 is the opposite.
- R2: Over J and K samples, a decoded bit is 1 when the level equals that of the previous J/K sample, and 0 when it toggles. The level is taken as J after reset and after any SE0.
- R3: While the byte enable is low, the decoded bit pattern 0,0,0,0,0,0,0,1 (oldest first) is recognised as SYNC. This raises byte_en, pulses sop for one cycle, clears stuff_err and frame_err, and counts the final SYNC 1 as the first bit of a run of ones.
- R4: One or more SE0 samples followed by a J sample, with at least two SE0 samples, is an end of packet. It pulses eop for one cycle and drops byte_en. The J sample is not a data bit.
- R5: Data bits after SYNC are packed least significant bit first. Each completed byte is written to the FIFO, and bytes read out in arrival order on fifo_data while fifo_rd is pulsed.
- R6: After six consecutive 1s in the packet, the next bit is discarded and the run count restarts.
- R7: If the discarded bit after six 1s is a 1, stuff_err is set. It stays set until the next SYNC.
- R8: If an end of packet arrives while 1 to 7 bits of a byte are pending, those bits are discarded and frame_err is set until the next SYNC.
- R9: bus_reset is high once the number of consecutive SE0 samples reaches 30 in full speed or 4 in low speed. It falls on the next non-SE0 sample.
- R10: While byte_en is low, resume pulses once when the run of consecutive K samples first exceeds resume_limit. The value of resume_limit is assumed to be at least 2.
- R11: The FIFO holds 32 bytes, and fifo_full_irq is high while it holds 32. A byte arriving while it is full is dropped, and fifo_empty is high while it holds none.
- R12: idle is high when the latest strobed sample was J and byte_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_dp | input | 1 | Synchronised D+ sample |
| line_dm | input | 1 | Synchronised D- sample |
| bit_stb | input | 1 | One-cycle strobe at each bit centre |
| low_speed | input | 1 | 1 selects low-speed J/K polarity and reset length |
| resume_limit | input | 8 | K bit times tolerated on an idle bus before resume |
| fifo_rd | input | 1 | Pops the head byte of the receive FIFO |
| fifo_data | output | 8 | Head byte of the receive FIFO (show-ahead) |
| fifo_empty | output | 1 | FIFO holds no byte |
| fifo_full_irq | output | 1 | FIFO full interrupt |
| byte_en | output | 1 | Byte assembly enabled (SYNC seen, EOP not yet) |
| sop | output | 1 | One-cycle start-of-packet pulse |
| eop | output | 1 | One-cycle end-of-packet pulse |
| idle | output | 1 | Bus idle |
| bus_reset | output | 1 | Bus reset condition |
| resume | output | 1 | One-cycle resume pulse |
| stuff_err | output | 1 | Bit-stuffing violation in the current packet |
| frame_err | output | 1 | Packet ended on a partial byte |

## Verification
The assertions assume that bit_stb is never high on two adjacent clock cycles. They also assume that resume_limit is at least 2, so that the pair of K samples at the end of a SYNC never counts as resume. The bench drives one strobe every fourth cycle, changes the line only together with a strobe, and sets resume_limit to 5. Packets are built by a bench-side NRZI encoder with its own stuffing counter. The stuffing and framing errors are produced by bypassing that encoder on purpose.

// File: rtl/usbrx_pkg.sv
// Shared types for the USB receive front end.
package usbrx_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'd0,
        LS_J   = 2'd1,
        LS_K   = 2'd2,
        LS_SE1 = 2'd3
    } line_st_t;

    // Maps a D+/D- sample pair to a line state; ls selects low-speed polarity.
    function automatic line_st_t classify(input logic dp, input logic dm, input logic ls);
        line_st_t st;
        case ({dp, dm})
            2'b00:   st = LS_SE0;
            2'b11:   st = LS_SE1;
            2'b10:   st = ls ? LS_K : LS_J;
            default: st = ls ? LS_J : LS_K;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/usbrx_line_mon.sv
// Line monitor: tracks SE0 and K runs across bit strobes and reports
// end of packet, bus reset, resume and idle.
// Assumes bit_stb is never high on adjacent cycles.
module usbrx_line_mon
    import usbrx_pkg::*;
#(
    parameter int RST_FS_BITS = 30,
    parameter int RST_LS_BITS = 4,
    parameter int LIM_W       = 8,
    parameter int SE0_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  line_st_t         cur_st,
    input  logic             low_speed,
    input  logic [LIM_W-1:0] resume_limit,
    input  logic             rx_busy,
    output logic             eop_o,
    output logic             bus_reset_o,
    output logic             resume_o,
    output logic             idle_o
);
    localparam logic [SE0_W-1:0] SE0_MAX = {SE0_W{1'b1}};
    localparam logic [LIM_W:0]   K_MAX   = {(LIM_W+1){1'b1}};

    line_st_t         last_st;
    logic [SE0_W-1:0] se0_cnt;
    logic [SE0_W-1:0] se0_inc;
    logic [SE0_W-1:0] rst_thr;
    logic [LIM_W:0]   k_cnt;
    logic [LIM_W:0]   k_inc;
    logic [LIM_W:0]   k_trip;

    // Saturating next values of the run counters and the reset threshold.
    always_comb begin
        se0_inc = (se0_cnt == SE0_MAX) ? se0_cnt : se0_cnt + 1'b1;
        k_inc   = (k_cnt == K_MAX) ? k_cnt : k_cnt + 1'b1;
        k_trip  = {1'b0, resume_limit} + 1'b1;
        rst_thr = low_speed ? SE0_W'(RST_LS_BITS) : SE0_W'(RST_FS_BITS);
    end

    // Run counters and line-condition outputs, updated on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_st     <= LS_J;
            se0_cnt     <= '0;
            k_cnt       <= '0;
            eop_o       <= 1'b0;
            bus_reset_o <= 1'b0;
            resume_o    <= 1'b0;
        end else begin
            eop_o    <= 1'b0;
            resume_o <= 1'b0;
            if (bit_stb) begin
                last_st     <= cur_st;
                se0_cnt     <= (cur_st == LS_SE0) ? se0_inc : '0;
                eop_o       <= (cur_st == LS_J) && (se0_cnt >= SE0_W'(2));
                bus_reset_o <= (cur_st == LS_SE0) && (se0_inc >= rst_thr);
                if (cur_st == LS_K && !rx_busy) begin
                    k_cnt    <= k_inc;
                    resume_o <= (k_inc == k_trip) && (k_cnt != K_MAX);
                end else begin
                    k_cnt <= '0;
                end
            end
        end
    end

    // Idle view: line resting at J and no packet being assembled.
    always_comb idle_o = (last_st == LS_J) && !rx_busy;

    // R9
    rst_on_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset_o |-> last_st == LS_SE0);

    // R10
    resume_on_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> last_st == LS_K);

    // R4
    eop_after_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> last_st == LS_J);

endmodule

// File: rtl/usbrx_bit_dec.sv
// Bit decoder: NRZI decode, SYNC hunt, stuffed-bit removal and LSB-first
// byte packing, gated by the byte enable that SYNC opens and EOP closes.
// Assumes eop_in arrives one cycle after the strobe that completed EOP.
module usbrx_bit_dec
    import usbrx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int RUN_LIMIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  line_st_t          cur_st,
    input  logic              eop_in,
    output logic              byte_en,
    output logic              sop_o,
    output logic              push_o,
    output logic [BYTE_W-1:0] push_data,
    output logic              stuff_err,
    output logic              frame_err
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam int RN_W = $clog2(RUN_LIMIT + 1);
    localparam logic [BYTE_W-1:0] SYNC_PAT = BYTE_W'(1);

    logic              prev_lvl;
    logic              after_se0;
    logic [BYTE_W-1:0] hunt;
    logic [BYTE_W-1:0] hunt_nx;
    logic [BYTE_W-1:0] shreg;
    logic [BC_W-1:0]   bcnt;
    logic [RN_W-1:0]   ones;
    logic              lvl;
    logic              nrzi;
    logic              jk_stb;

    // NRZI decode of the current sample against the previous level.
    always_comb begin
        lvl     = (cur_st == LS_J);
        nrzi    = (lvl == prev_lvl);
        jk_stb  = bit_stb && (cur_st == LS_J || cur_st == LS_K);
        hunt_nx = {hunt[BYTE_W-2:0], nrzi};
    end

    // Packet state machine: hunt, destuff, pack, and close on EOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl  <= 1'b1;
            after_se0 <= 1'b0;
            hunt      <= '1;
            shreg     <= '0;
            bcnt      <= '0;
            ones      <= '0;
            byte_en   <= 1'b0;
            sop_o     <= 1'b0;
            push_o    <= 1'b0;
            push_data <= '0;
            stuff_err <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            sop_o  <= 1'b0;
            push_o <= 1'b0;
            if (eop_in) begin
                if (byte_en && bcnt != '0) frame_err <= 1'b1;
                byte_en <= 1'b0;
                bcnt    <= '0;
                ones    <= '0;
                hunt    <= '1;
            end else if (bit_stb && cur_st == LS_SE0) begin
                prev_lvl  <= 1'b1;
                after_se0 <= 1'b1;
            end else if (jk_stb) begin
                prev_lvl  <= lvl;
                after_se0 <= 1'b0;
                if (after_se0) begin
                    hunt <= '1;
                end else if (!byte_en) begin
                    hunt <= hunt_nx;
                    if (hunt_nx == SYNC_PAT) begin
                        byte_en   <= 1'b1;
                        sop_o     <= 1'b1;
                        ones      <= RN_W'(1);
                        bcnt      <= '0;
                        stuff_err <= 1'b0;
                        frame_err <= 1'b0;
                    end
                end else if (ones == RN_W'(RUN_LIMIT)) begin
                    ones <= '0;
                    if (nrzi) stuff_err <= 1'b1;
                end else begin
                    shreg <= {nrzi, shreg[BYTE_W-1:1]};
                    ones  <= nrzi ? ones + 1'b1 : '0;
                    if (bcnt == BC_W'(BYTE_W - 1)) begin
                        push_o    <= 1'b1;
                        push_data <= {nrzi, shreg[BYTE_W-1:1]};
                        bcnt      <= '0;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
            end
        end
    end

    // R3
    sop_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sop_o |=> byte_en);

    // R4
    eop_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_in |=> !byte_en);

    // R5
    push_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(byte_en));

    // R8
    frame_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(eop_in));

endmodule

// File: rtl/usbrx_fifo.sv
// Receive FIFO with show-ahead read; a write while full is dropped.
// Assumes DEPTH is at least 2.
module usbrx_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [AW:0]   cnt;
    logic          do_wr;
    logic          do_rd;

    // Accepted operations and status flags.
    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == (AW+1)'(DEPTH));
        do_wr = push && !full;
        do_rd = pop && !empty;
        rdata = mem[rp];
    end

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wp] <= wdata;
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_rd) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R11
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

    // R11
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/usb_rx_front.sv
// USB receive front end top: classifies the strobed line, runs the line
// monitor and bit decoder, and buffers assembled bytes in a FIFO.
// Assumes synchronised line inputs and bit_stb never high on adjacent cycles.
module usb_rx_front
    import usbrx_pkg::*;
#(
    parameter int FIFO_DEPTH  = 32,
    parameter int BYTE_W      = 8,
    parameter int LIM_W       = 8,
    parameter int RST_FS_BITS = 30,
    parameter int RST_LS_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_dp,
    input  logic              line_dm,
    input  logic              bit_stb,
    input  logic              low_speed,
    input  logic [LIM_W-1:0]  resume_limit,
    input  logic              fifo_rd,
    output logic [BYTE_W-1:0] fifo_data,
    output logic              fifo_empty,
    output logic              fifo_full_irq,
    output logic              byte_en,
    output logic              sop,
    output logic              eop,
    output logic              idle,
    output logic              bus_reset,
    output logic              resume,
    output logic              stuff_err,
    output logic              frame_err
);
    line_st_t          cur_st;
    logic              push;
    logic [BYTE_W-1:0] push_data;

    // Line state of the current sample under the selected polarity.
    always_comb cur_st = classify(line_dp, line_dm, low_speed);

    usbrx_line_mon #(
        .RST_FS_BITS (RST_FS_BITS),
        .RST_LS_BITS (RST_LS_BITS),
        .LIM_W       (LIM_W)
    ) mon_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bit_stb      (bit_stb),
        .cur_st       (cur_st),
        .low_speed    (low_speed),
        .resume_limit (resume_limit),
        .rx_busy      (byte_en),
        .eop_o        (eop),
        .bus_reset_o  (bus_reset),
        .resume_o     (resume),
        .idle_o       (idle)
    );

    usbrx_bit_dec #(
        .BYTE_W (BYTE_W)
    ) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .cur_st    (cur_st),
        .eop_in    (eop),
        .byte_en   (byte_en),
        .sop_o     (sop),
        .push_o    (push),
        .push_data (push_data),
        .stuff_err (stuff_err),
        .frame_err (frame_err)
    );

    usbrx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (BYTE_W)
    ) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .wdata (push_data),
        .pop   (fifo_rd),
        .rdata (fifo_data),
        .empty (fifo_empty),
        .full  (fifo_full_irq)
    );

    // R3
    sop_eop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sop, eop}));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !byte_en);

endmodule

// File: tb/usb_rx_front_tb_top.sv
// Directed bench for usb_rx_front: one task per scenario, each checking itself.
module usb_rx_front_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_dp = 1'b1;
    logic       line_dm = 1'b0;
    logic       bit_stb = 1'b0;
    logic       low_speed = 1'b0;
    logic [7:0] resume_limit = 8'd5;
    logic       fifo_rd = 1'b0;
    logic [7:0] fifo_data;
    logic       fifo_empty, fifo_full_irq, byte_en, sop, eop, idle;
    logic       bus_reset, resume, stuff_err, frame_err;

    int checks = 0;
    int fails  = 0;
    int sop_n = 0, eop_n = 0, res_n = 0;
    logic cur = 1'b1;
    int   ones = 0;
    bit   done = 0;

    always #2 clk = ~clk;

    usb_rx_front dut_i (
        .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
        .bit_stb(bit_stb), .low_speed(low_speed), .resume_limit(resume_limit),
        .fifo_rd(fifo_rd), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_full_irq(fifo_full_irq), .byte_en(byte_en), .sop(sop), .eop(eop),
        .idle(idle), .bus_reset(bus_reset), .resume(resume),
        .stuff_err(stuff_err), .frame_err(frame_err)
    );

    // Pulse counters observed at the ports.
    always @(posedge clk) begin
        if (sop) sop_n++;
        if (eop) eop_n++;
        if (resume) res_n++;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic line_bit(input logic dp, input logic dm);
        @(negedge clk);
        line_dp = dp; line_dm = dm; bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drive_lvl(input logic j);
        if (j) line_bit(!low_speed, low_speed);
        else   line_bit(low_speed, !low_speed);
    endtask

    task automatic tx_nrzi(input logic b);
        if (!b) cur = ~cur;
        drive_lvl(cur);
    endtask

    task automatic tx_sync();
        for (int i = 0; i < 7; i++) tx_nrzi(1'b0);
        tx_nrzi(1'b1);
        ones = 1;
    endtask

    task automatic tx_data(input logic b);
        tx_nrzi(b);
        ones = b ? ones + 1 : 0;
        if (ones == 6) begin
            tx_nrzi(1'b0);
            ones = 0;
        end
    endtask

    task automatic tx_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_data(v[i]);
    endtask

    task automatic tx_eop();
        line_bit(1'b0, 1'b0);
        line_bit(1'b0, 1'b0);
        cur = 1'b1;
        drive_lvl(1'b1);
    endtask

    task automatic tx_idle(input int n);
        cur = 1'b1;
        for (int i = 0; i < n; i++) drive_lvl(1'b1);
    endtask

    task automatic pop_byte(input string req, input logic [7:0] exp);
        @(negedge clk);
        chk(req, fifo_empty, 0);
        chk(req, fifo_data, exp);
        fifo_rd = 1'b1;
        @(negedge clk);
        fifo_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 idle after reset", idle, 1);
        chk("R11 empty after reset", fifo_empty, 1);
        chk("R11 full after reset", fifo_full_irq, 0);
        chk("R3 byte_en after reset", byte_en, 0);
        chk("R9 bus_reset after reset", bus_reset, 0);
        chk("R7 stuff_err after reset", stuff_err, 0);
    endtask

    task automatic t_basic();
        int s0, e0;
        s0 = sop_n; e0 = eop_n;
        tx_idle(4);
        tx_sync();
        chk("R3 byte_en after SYNC", byte_en, 1);
        chk("R3 sop pulse", sop_n - s0, 1);
        tx_byte(8'hA5);
        tx_byte(8'h3C);
        chk("R12 not idle in packet", idle, 0);
        tx_eop();
        tx_idle(2);
        chk("R4 byte_en after EOP", byte_en, 0);
        chk("R4 eop pulse", eop_n - e0, 1);
        chk("R8 no frame_err", frame_err, 0);
        chk("R12 idle after packet", idle, 1);
        pop_byte("R5 first byte", 8'hA5);
        pop_byte("R2 second byte", 8'h3C);
        chk("R5 empty after reads", fifo_empty, 1);
    endtask

    task automatic t_stuff();
        tx_idle(3);
        tx_sync();
        tx_byte(8'hFF);
        tx_byte(8'hFF);
        tx_byte(8'h7E);
        tx_eop();
        tx_idle(2);
        chk("R7 no stuff_err", stuff_err, 0);
        pop_byte("R6 stuffed FF a", 8'hFF);
        pop_byte("R6 stuffed FF b", 8'hFF);
        pop_byte("R6 stuffed 7E", 8'h7E);
        chk("R6 empty", fifo_empty, 1);
    endtask

    task automatic t_stuff_err();
        tx_idle(3);
        tx_sync();
        for (int i = 0; i < 6; i++) tx_nrzi(1'b1);
        tx_eop();
        tx_idle(2);
        chk("R7 stuff_err set", stuff_err, 1);
        chk("R7 no byte stored", fifo_empty, 1);
    endtask

    task automatic t_frame();
        tx_idle(3);
        tx_sync();
        chk("R7 stuff_err cleared by SYNC", stuff_err, 0);
        tx_byte(8'h55);
        for (int i = 0; i < 4; i++) tx_data(1'b1);
        tx_eop();
        tx_idle(2);
        chk("R8 frame_err set", frame_err, 1);
        pop_byte("R8 whole byte kept", 8'h55);
        chk("R8 partial byte dropped", fifo_empty, 1);
    endtask

    task automatic t_low();
        low_speed = 1'b1;
        tx_idle(3);
        chk("R1 low-speed J is idle", idle, 1);
        tx_sync();
        chk("R8 frame_err cleared by SYNC", frame_err, 0);
        tx_byte(8'hC3);
        tx_eop();
        tx_idle(2);
        pop_byte("R1 low-speed byte", 8'hC3);
        for (int i = 0; i < 3; i++) line_bit(1'b0, 1'b0);
        chk("R9 low-speed 3 SE0", bus_reset, 0);
        line_bit(1'b0, 1'b0);
        chk("R9 low-speed 4 SE0", bus_reset, 1);
        tx_idle(1);
        chk("R9 reset released", bus_reset, 0);
        low_speed = 1'b0;
        tx_idle(2);
    endtask

    task automatic t_busrst();
        for (int i = 0; i < 29; i++) line_bit(1'b0, 1'b0);
        chk("R9 full-speed 29 SE0", bus_reset, 0);
        line_bit(1'b0, 1'b0);
        chk("R9 full-speed 30 SE0", bus_reset, 1);
        tx_idle(2);
        chk("R9 released", bus_reset, 0);
    endtask

    task automatic t_resume();
        int r0;
        tx_idle(3);
        r0 = res_n;
        for (int i = 0; i < 5; i++) drive_lvl(1'b0);
        chk("R10 no resume at limit", res_n - r0, 0);
        drive_lvl(1'b0);
        chk("R10 resume past limit", res_n - r0, 1);
        for (int i = 0; i < 3; i++) drive_lvl(1'b0);
        chk("R10 single pulse", res_n - r0, 1);
        tx_idle(3);
    endtask

    task automatic t_full();
        tx_idle(3);
        tx_sync();
        for (int i = 0; i < 33; i++) tx_byte(8'(i * 7 + 1));
        tx_eop();
        tx_idle(2);
        chk("R11 full irq", fifo_full_irq, 1);
        for (int i = 0; i < 32; i++) pop_byte("R11 FIFO order", 8'(i * 7 + 1));
        chk("R11 33rd byte dropped", fifo_empty, 1);
        chk("R11 full cleared", fifo_full_irq, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_stuff();
        t_stuff_err();
        t_frame();
        t_low();
        t_busrst();
        t_resume();
        t_full();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule